// File: doc/BRIEF.md
# I2C Master Receiver with Clock Stretching on a Full Buffer

This block is the receive side of a two-wire bus master. A start strobe, together with a 7-bit target address and a nonzero byte count, makes it issue a START condition and send the address with the read bit set. It then clocks in exactly the programmed number of data bytes, MSB first, and places each one in a two-entry receive buffer. It acknowledges every byte except the final one. The final byte gets a not-acknowledge and is followed by a STOP condition.

The buffer is drained through two read strobes. One takes a single byte and the other takes both bytes at once. A 2-bit status field reports how full the buffer is. If the buffer fills while more bytes are still due, the master holds the clock line low during that byte's acknowledge bit and does not begin the next byte. Draining the buffer is the only thing that lets the transfer continue. Two sticky interrupt flags, cleared by write-one strobes, report that the buffer filled and that the transfer ended. Both bus lines are open drain: the block only ever pulls a line low or lets it float.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, both line enables are off, `busy` is 0, `fifo_stat` is 00 and both interrupt flags are 0.
- R2: A `go` pulse with a nonzero `xfer_cnt` produces a START, then the seven address bits MSB first, then a read bit of value 1. A `go` pulse with `xfer_cnt` equal to 0 is ignored: no START occurs and `busy` stays 0.
- R3: If the address is not acknowledged (SDA high in the ninth clock), the block issues STOP, sets the done flag and stores no data.
- R4: Received bytes are assembled MSB first. `fifo_stat` encodes the level as 00 for empty, 01 for one byte and 11 for two bytes. With one byte held, `rd_data` is {8'h00, byte}.
- R5: A pulse on `rd8` removes the oldest byte, which is shown on `rd_data[7:0]`. A pulse on `rd16` removes both bytes only when two are held, and `rd_data` is then {newer, older}. A pulse on `rd16` with one byte held changes nothing.
- R6: `irq_full` (flag bit 0) is set when the buffer goes to two bytes and holds until a write-one on `irq_clr[0]`. It is never set if every byte is read before the next one arrives.
- R7: When the buffer is full and bytes remain, SCL stays low after the falling edge that ends the byte, and no further bit is clocked for as long as the buffer stays full.
- R8: Reading the buffer is the only thing needed for clocking to resume. SCL rises within a few quarter periods of the read.
- R9: Exactly `xfer_cnt` bytes are clocked in. The master acknowledges each byte (SDA low) except the last, which gets a not-acknowledge (SDA high), and then issues one STOP.
- R10: `irq_done` (flag bit 1) is set when STOP completes and `busy` falls. It holds until a write-one on `irq_clr[1]`.
- R11: One quarter of the SCL period lasts `qtr_div`+1 clock cycles. Each SCL high phase lasts 2·(`qtr_div`+1)+2 cycles; the extra 2 cycles come from the line synchronizer. Lines are released by clearing the enable, never driven high.
- R12: If the final byte fills the buffer, no stretch occurs. The transfer completes with both bytes still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start-of-transfer strobe (accepted when idle) |
| slv_addr | input | 7 | Target address |
| xfer_cnt | input | CNT_W | Number of bytes to receive |
| qtr_div | input | DIV_W | Quarter-period divider (cycles minus one) |
| scl_i | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rd8 | input | 1 | Pop one byte |
| rd16 | input | 1 | Pop two bytes |
| rd_data | output | 16 | Buffer contents, oldest byte in the low half |
| fifo_stat | output | 2 | Buffer level code |
| irq_clr | input | 2 | Write-one-to-clear for the flags (bit 0 full, bit 1 done) |
| irq_full | output | 1 | Buffer-full flag |
| irq_done | output | 1 | Transfer-complete flag |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps byte counts 1 to 6 at three divider settings, using both a prompt single-byte drain and a lazy drain that waits for the buffer to fill. The lazy drain pins down the stretch. A design that kept clocking while full would move the bus model's bit counter during the hold or raise SCL. A design that waited for the flag clear instead of the read would never rise again. An even count where the last byte fills the buffer catches a design that stretches needlessly and never reaches STOP. The bench also checks the acknowledge log for a last byte wrongly acknowledged, a missing address-NACK abort, a count-zero start that is not ignored, and a two-byte read that wrongly pops a lone byte.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_MACK,
    ST_STOP
  } rx_state_e;

endpackage

// File: rtl/i2c_rx_qtick.sv
module i2c_rx_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick = en && (cnt_q >= div);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> cnt_q == '0); // R11

endmodule

// File: rtl/i2c_rx_fifo2.sv
module i2c_rx_fifo2 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [7:0]  wdata,
  input  logic        pop1,
  input  logic        pop2,
  output logic [15:0] rdata,
  output logic [1:0]  status,
  output logic        full,
  output logic        fill_evt
);

  logic [1:0] lvl_q, lvl_d, lvl_mid;
  logic [7:0] e0_q, e0_d, e1_q, e1_d;
  logic       do_pop1, do_pop2, do_push;

  assign do_pop2 = pop2 && (lvl_q == 2'd2);
  assign do_pop1 = pop1 && !pop2 && (lvl_q != 2'd0);
  assign do_push = push && (lvl_q != 2'd2);

  always_comb begin
    e0_d = e0_q;
    e1_d = e1_q;
    if (do_pop2)      lvl_mid = 2'd0;
    else if (do_pop1) lvl_mid = lvl_q - 2'd1;
    else              lvl_mid = lvl_q;
    if (do_pop1) e0_d = e1_q;
    if (do_push) begin
      if (lvl_mid == 2'd0) e0_d = wdata;
      else                 e1_d = wdata;
    end
    lvl_d = lvl_mid + {1'b0, do_push};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 2'd0;
      e0_q  <= 8'h00;
      e1_q  <= 8'h00;
    end else begin
      lvl_q <= lvl_d;
      e0_q  <= e0_d;
      e1_q  <= e1_d;
    end
  end

  assign full     = (lvl_q == 2'd2);
  assign fill_evt = (lvl_q != 2'd2) && (lvl_d == 2'd2);
  assign status   = {lvl_q == 2'd2, lvl_q != 2'd0};
  assign rdata    = {(lvl_q == 2'd2) ? e1_q : 8'h00, (lvl_q != 2'd0) ? e0_q : 8'h00};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> lvl_q != 2'd2); // R4
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q != 2'd3); // R4
  AST_WIDE_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop2 && lvl_q == 2'd2 && !push) |=> lvl_q == 2'd0); // R5

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [6:0]       addr,
  input  logic [CNT_W-1:0] count,
  input  logic             tick,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             fifo_full,
  output logic             tick_en,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             push,
  output logic [7:0]       wdata,
  output logic             busy,
  output logic             done_evt
);

  rx_state_e        st_q, st_d;
  logic [1:0]       qtr_q, qtr_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             sda_prev_q, sda_prev_d;
  logic [1:0]       scl_sync_q, sda_sync_q;
  logic             scl_s, sda_s, last, stall, slave_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
    end
  end
  assign scl_s = scl_sync_q[1];
  assign sda_s = sda_sync_q[1];

  assign last       = (rem_q == CNT_W'(1));
  assign stall      = (st_q == ST_MACK) && (qtr_q == 2'd1) && fifo_full && !last;
  assign slave_hold = !scl_oe && !scl_s;
  assign tick_en    = (st_q != ST_IDLE) && !stall && !slave_hold;
  assign busy       = (st_q != ST_IDLE);
  assign wdata      = {sh_q[6:0], sda_s};

  always_comb begin
    case (st_q)
      ST_IDLE:  scl_oe = 1'b0;
      ST_START: scl_oe = qtr_q[1];
      default:  scl_oe = !qtr_q[1];
    endcase
  end

  always_comb begin
    if (st_q == ST_IDLE)       sda_oe = 1'b0;
    else if (st_q == ST_START) sda_oe = (qtr_q != 2'd0);
    else if (qtr_q == 2'd0)    sda_oe = sda_prev_q;
    else begin
      case (st_q)
        ST_ADDR: sda_oe = !sh_q[7];
        ST_MACK: sda_oe = !last;
        ST_STOP: sda_oe = (qtr_q != 2'd3);
        default: sda_oe = 1'b0;
      endcase
    end
  end

  always_comb begin
    st_d       = st_q;
    qtr_d      = qtr_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    rem_d      = rem_q;
    sda_prev_d = sda_prev_q;
    push       = 1'b0;
    done_evt   = 1'b0;
    if (st_q == ST_IDLE) begin
      if (go && (count != '0)) begin
        st_d  = ST_START;
        qtr_d = 2'd0;
        bit_d = 3'd0;
        rem_d = count;
        sh_d  = {addr, 1'b1};
      end
    end else if (tick) begin
      qtr_d = qtr_q + 2'd1;
      if (qtr_q == 2'd3) begin
        sda_prev_d = sda_oe;
        case (st_q)
          ST_START: begin
            st_d  = ST_ADDR;
            bit_d = 3'd0;
          end
          ST_ADDR: begin
            sh_d  = {sh_q[6:0], 1'b0};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) st_d = ST_AACK;
          end
          ST_AACK: begin
            bit_d = 3'd0;
            st_d  = sda_s ? ST_STOP : ST_DATA;
          end
          ST_DATA: begin
            sh_d  = wdata;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              push = 1'b1;
              st_d = ST_MACK;
            end
          end
          ST_MACK: begin
            rem_d = rem_q - CNT_W'(1);
            bit_d = 3'd0;
            st_d  = last ? ST_STOP : ST_DATA;
          end
          ST_STOP: begin
            st_d     = ST_IDLE;
            done_evt = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      qtr_q      <= 2'd0;
      bit_q      <= 3'd0;
      sh_q       <= 8'h00;
      rem_q      <= '0;
      sda_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      qtr_q      <= qtr_d;
      bit_q      <= bit_d;
      sh_q       <= sh_d;
      rem_q      <= rem_d;
      sda_prev_q <= sda_prev_d;
    end
  end

  AST_NO_BYTE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> !fifo_full); // R7
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MACK && qtr_q == 2'd1 && fifo_full && !last) |=> (st_q == ST_MACK && qtr_q == 2'd1)); // R7
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q inside {ST_ADDR, ST_AACK, ST_DATA, ST_MACK}) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R11
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_DATA, ST_MACK}) |-> rem_q != '0); // R9

endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [6:0]       slv_addr,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic [DIV_W-1:0] qtr_div,
  input  logic             scl_i,
  output logic             scl_oe,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             rd8,
  input  logic             rd16,
  output logic [15:0]      rd_data,
  output logic [1:0]       fifo_stat,
  input  logic [1:0]       irq_clr,
  output logic             irq_full,
  output logic             irq_done,
  output logic             busy
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       tick, tick_en, push, fifo_full, fill_evt, done_evt;
  logic [7:0] wdata;
  logic       irq_full_d, irq_done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  i2c_rx_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n_s),
    .en   (tick_en),
    .div  (qtr_div),
    .tick (tick)
  );

  i2c_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (go),
    .addr     (slv_addr),
    .count    (xfer_cnt),
    .tick     (tick),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .fifo_full(fifo_full),
    .tick_en  (tick_en),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .push     (push),
    .wdata    (wdata),
    .busy     (busy),
    .done_evt (done_evt)
  );

  i2c_rx_fifo2 u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .push    (push),
    .wdata   (wdata),
    .pop1    (rd8),
    .pop2    (rd16),
    .rdata   (rd_data),
    .status  (fifo_stat),
    .full    (fifo_full),
    .fill_evt(fill_evt)
  );

  always_comb begin
    irq_full_d = fill_evt || (irq_full && !irq_clr[0]);
    irq_done_d = done_evt || (irq_done && !irq_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_full <= 1'b0;
      irq_done <= 1'b0;
    end else begin
      irq_full <= irq_full_d;
      irq_done <= irq_done_d;
    end
  end

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq_done) |-> !busy); // R10
  AST_FILL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n_s)
    fill_evt |=> irq_full); // R6

endmodule

// File: tb/tb_i2c_rx_master.sv
module tb_i2c_rx_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [6:0]  slv_addr;
  logic [7:0]  xfer_cnt;
  logic [7:0]  qtr_div;
  logic        scl_oe, sda_oe;
  logic        rd8, rd16;
  logic [15:0] rd_data;
  logic [1:0]  fifo_stat;
  logic [1:0]  irq_clr;
  logic        irq_full, irq_done, busy;
  logic        scl_w, sda_w;
  logic        slv_pull = 1'b0;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rx_master dut (
    .clk(clk), .rst_n(rst_n), .go(go), .slv_addr(slv_addr), .xfer_cnt(xfer_cnt),
    .qtr_div(qtr_div), .scl_i(scl_w), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe),
    .rd8(rd8), .rd16(rd16), .rd_data(rd_data), .fifo_stat(fifo_stat), .irq_clr(irq_clr),
    .irq_full(irq_full), .irq_done(irq_done), .busy(busy)
  );

  // ---------------- bus target model ----------------
  int         bitc = 0;
  int         starts = 0;
  int         stops = 0;
  int         acks_n = 0;
  int         cur_seed = 0;
  logic [7:0] addr_byte = 8'h00;
  logic [6:0] slv_match = 7'h00;
  logic       slv_done = 1'b0;
  logic       ack_log [0:15];

  function automatic logic [7:0] exp_byte(input int s, input int k);
    return 8'((k * 53 + s * 7 + 11) ^ 'h5A);
  endfunction

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    starts++;
    bitc = 0;
    acks_n = 0;
    slv_done = 1'b0;
  end

  always @(posedge sda_w) if (scl_w === 1'b1) stops++;

  always @(posedge scl_w) begin
    if (bitc < 8) addr_byte[7-bitc] = sda_w;
    if (bitc >= 9 && ((bitc - 9) % 9) == 8) begin
      if (acks_n < 16) ack_log[acks_n] = sda_w;
      acks_n++;
      if (sda_w) slv_done = 1'b1;
    end
    bitc++;
  end

  always @(negedge scl_w) begin
    logic [7:0] b;
    if (bitc == 8) begin
      slv_pull = (addr_byte[7:1] == slv_match);
      slv_done = !slv_pull;
    end else if (bitc >= 9 && !slv_done && ((bitc - 9) % 9) < 8) begin
      b = exp_byte(cur_seed, (bitc - 9) / 9);
      slv_pull = !b[7 - ((bitc - 9) % 9)];
    end else begin
      slv_pull = 1'b0;
    end
  end

  // SCL high-time monitor
  int hi_run = 0;
  int last_hi = 0;
  always @(posedge clk) begin
    if (scl_w) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  task automatic pulse_go(input int n, input int dv, input logic [6:0] a);
    xfer_cnt = 8'(n);
    qtr_div  = 8'(dv);
    slv_addr = a;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic run_xfer(input int dv, input int n, input int md);
    int got = 0;
    int guard = 0;
    int st0, sp0, seen_at, b0;
    bit rel;
    seen_at  = -1;
    cur_seed = dv * 16 + n * 3 + md;
    slv_match = 7'(7'h21 + n);
    st0 = starts;
    sp0 = stops;
    pulse_go(n, dv, slv_match);
    while (guard < 30000) begin
      guard++;
      rd8 = 1'b0; rd16 = 1'b0; irq_clr = 2'b00;
      if (!busy && fifo_stat == 2'b00) break;
      if (md == 0) begin
        if (fifo_stat != 2'b00) begin
          chk(rd_data[7:0] == exp_byte(cur_seed, got), "R5", "rd8 byte", rd_data[7:0], exp_byte(cur_seed, got));
          chk(irq_full == 1'b0, "R6", "no fill when drained promptly", irq_full, 0);
          rd8 = 1'b1;
          got++;
        end
      end else if (fifo_stat == 2'b11) begin
        chk(irq_full == 1'b1, "R6", "full flag on fill", irq_full, 1);
        chk(rd_data == {exp_byte(cur_seed, got + 1), exp_byte(cur_seed, got)}, "R5", "rd16 pair",
            rd_data, {exp_byte(cur_seed, got + 1), exp_byte(cur_seed, got)});
        if (got + 2 < n) begin
          b0 = bitc;
          rel = 1'b0;
          for (int i = 0; i < 40 * (dv + 1); i++) begin
            if (scl_w) rel = 1'b1;
            @(negedge clk);
          end
          chk(!rel, "R7", "SCL held low while full", rel, 0);
          chk(bitc == b0, "R7", "no bit clocked while full", bitc, b0);
          chk(busy == 1'b1, "R7", "still busy during stretch", busy, 1);
        end else begin
          for (int i = 0; i < 40 * (dv + 1) + 40 && busy; i++) @(negedge clk);
          chk(!busy && irq_done, "R12", "last byte fill completes without stretch", irq_done, 1);
        end
        rd16 = 1'b1;
        @(negedge clk);
        rd16 = 1'b0;
        chk(fifo_stat == 2'b00, "R5", "rd16 empties buffer", fifo_stat, 0);
        if (got + 2 < n) begin
          rel = 1'b0;
          for (int i = 0; i < 8 * (dv + 1) + 10 && !rel; i++) begin
            @(negedge clk);
            if (scl_w) rel = 1'b1;
          end
          chk(rel, "R8", "SCL released after read", rel, 1);
        end
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk(irq_full == 1'b0, "R6", "full flag cleared by write-one", irq_full, 0);
        got += 2;
      end else if (fifo_stat == 2'b01) begin
        if (!busy) begin
          rd16 = 1'b1;
          @(negedge clk);
          rd16 = 1'b0;
          chk(fifo_stat == 2'b01, "R5", "rd16 ignored with one byte", fifo_stat, 1);
          chk(rd_data[7:0] == exp_byte(cur_seed, got), "R5", "rd8 lone byte", rd_data[7:0], exp_byte(cur_seed, got));
          rd8 = 1'b1;
          got++;
        end else if (seen_at != got) begin
          seen_at = got;
          chk(rd_data == {8'h00, exp_byte(cur_seed, got)}, "R4", "one-byte view", rd_data, {8'h00, exp_byte(cur_seed, got)});
        end
      end
      @(negedge clk);
    end
    rd8 = 1'b0; rd16 = 1'b0;
    chk(got == n, "R9", "bytes received", got, n);
    chk(acks_n == n, "R9", "acknowledge bits seen", acks_n, n);
    for (int k = 0; k < n && k < 16; k++)
      chk(ack_log[k] == (k == n - 1), "R9", "ack/nack per byte", ack_log[k], (k == n - 1));
    chk(addr_byte == {slv_match, 1'b1}, "R2", "address and read bit", addr_byte, {slv_match, 1'b1});
    chk(starts == st0 + 1, "R2", "one START", starts - st0, 1);
    chk(stops == sp0 + 1, "R9", "one STOP", stops - sp0, 1);
    chk(irq_done == 1'b1 && !busy, "R10", "done flag at end", irq_done, 1);
    chk(last_hi == 2 * dv + 4, "R11", "SCL high time", last_hi, 2 * dv + 4);
    @(negedge clk) irq_clr = 2'b11;
    @(negedge clk) irq_clr = 2'b00;
    chk(irq_done == 1'b0, "R10", "done flag cleared by write-one", irq_done, 0);
  endtask

  initial begin
    int st0, sp0;
    rst_n = 1'b0; go = 1'b0; rd8 = 1'b0; rd16 = 1'b0; irq_clr = 2'b00;
    slv_addr = 7'h00; xfer_cnt = 8'd0; qtr_div = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1", "lines floating", {scl_oe, sda_oe}, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(fifo_stat == 2'b00, "R1", "status after reset", fifo_stat, 0);
    chk(!irq_full && !irq_done, "R1", "flags after reset", {irq_full, irq_done}, 0);

    // R2 count zero ignored
    st0 = starts;
    pulse_go(0, 1, 7'h15);
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R2", "zero count not started", busy, 0);
    chk(starts == st0 && scl_w, "R2", "no START on zero count", starts - st0, 0);

    // R3 address not acknowledged
    st0 = starts; sp0 = stops;
    slv_match = 7'h33;
    cur_seed = 1;
    pulse_go(3, 1, 7'h32);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk(!busy && irq_done, "R3", "done after address nack", irq_done, 1);
    chk(fifo_stat == 2'b00 && !irq_full, "R3", "no data after address nack", fifo_stat, 0);
    chk(acks_n == 0 && stops == sp0 + 1, "R3", "STOP, no data bytes", stops - sp0, 1);
    chk(starts == st0 + 1, "R3", "single START", starts - st0, 1);
    @(negedge clk) irq_clr = 2'b10;
    @(negedge clk) irq_clr = 2'b00;

    // main sweep
    for (int dv = 0; dv < 4; dv++) begin
      if (dv == 2) continue;
      for (int n = 1; n <= 6; n++)
        for (int md = 0; md < 2; md++)
          run_xfer(dv, n, md);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule